// File: doc/BRIEF.md
# ISA DMA Bus-Master Handshake Controller

This block lets a device take the expansion bus away from the motherboard and run its own memory cycles as an alternate master. A one-clock request pulse, carrying a start address and a word count, makes it raise the DMA request line. It then waits for the host's acknowledge, which passes through a two-stage synchroniser. Once the synchronised acknowledge is low, the block claims ownership. It runs one 16-bit memory cycle per word, with byte-high enable driven throughout. Each cycle is stretched while the channel-ready input is held low.

After the last word the block drops the request line and pulses a done flag. It releases ownership one clock later. It then waits out a spacing delay before it may raise the request line again. The delay adapts to how long the host took to grant the bus: a slow grant means the bus is busy with another master, so the delay doubles; a quick grant halves it. This shares bandwidth fairly with a second bus master.

One further request can wait in a single slot while a burst or its spacing delay is in progress.

The state machine has six states:
- IDLE: no burst and no waiting request.
- REQ: request line up, waiting for the synchronised acknowledge.
- ADDR: address setup clock.
- CMD: memory strobe low.
- DROP: request line down, ownership still held.
- GAP: spacing delay.

Its transitions are:
- IDLE to REQ: on a request pulse or a held request.
- REQ to ADDR: the grant.
- ADDR to CMD: always, after one clock.
- CMD to ADDR: end of a word that is not the last.
- CMD to DROP: end of the last word.
- DROP to GAP: always, after one clock.
- GAP to REQ: delay over with a request held.
- GAP to IDLE: delay over with none held.

Top module: `dma_bus_master`

## Requirements
- R1: While reset is asserted, the outputs are: request low, ownership high (inactive), memory strobe high, byte-high enable high, done low, address 0.
- R2: A request pulse sampled while idle raises the request line on the next clock. While idle with nothing held, the request line stays low.
- R3: The acknowledge (active low) is used only after two flip-flops. Ownership (active low) goes low in the third clock after the acknowledge is driven low, and the request line stays high until then.
- R4: Each word takes one address-setup clock and then at least 3 clocks of memory strobe low. During both, the request line is high, ownership and byte-high enable are low, and the address is held. The address starts at the requested value and steps by 2 for each word, wrapping modulo 2^16.
- R5: From the third strobe clock on, the strobe stays low for every clock edge at which channel-ready is low. It ends at the first such edge at which channel-ready is high.
- R6: A burst runs exactly the requested number of words; a count of 0 runs one word.
- R7: After the last word, the request line drops and done is high for exactly that one clock while ownership is still held. Ownership is released on the next clock.
- R8: When a request is held, the request line stays low for exactly D+1 clocks between bursts, where D is the current spacing delay.
- R9: The spacing delay starts at 4 after reset. Let N be the number of clocks the request line was high before ownership was taken. If N > 6, the delay doubles, capped at 15. Otherwise it halves, with a floor of 1. The new value applies to the spacing that follows that burst.
- R10: A request pulse that arrives while a request is already held is dropped. It affects neither address nor length, and no extra burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-clock request pulse |
| req_addr_i | input | 16 | Start address of the burst |
| req_len_i | input | 8 | Word count of the burst (0 means 1) |
| dack_n_i | input | 1 | DMA acknowledge from host, active low, asynchronous |
| chrdy_i | input | 1 | Channel ready; low stretches the current cycle |
| drq_o | output | 1 | DMA request to host |
| master_n_o | output | 1 | Bus ownership claim, active low |
| addr_o | output | 16 | Memory address, valid during setup and strobe |
| sbhe_n_o | output | 1 | Byte-high enable, active low |
| mem_strobe_n_o | output | 1 | Memory command strobe, active low |
| done_o | output | 1 | One-clock pulse when the burst ends |

## Verification
The assertions assume that the host holds the acknowledge low from the grant until the request line drops, and releases it before the next request. They also assume that channel-ready changes only between clock edges. The bench keeps within this as follows. It drives the acknowledge low only after seeing the request line high. It raises the acknowledge in the same clock in which the request line falls. It drives channel-ready and the request pulses only on falling edges. It issues a held request, and the pulse that must be dropped, only while a burst is running.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_CMD  = 3'd3,
        ST_DROP = 3'd4,
        ST_GAP  = 3'd5
    } dbm_state_e;

endpackage

// File: rtl/dbm_sync.sv
module dbm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic s_q;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= RST_VAL;
                else        s_q <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= RST_VAL;
                else        s_q <= g_stage[i-1].s_q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].s_q;

endmodule

// File: rtl/dbm_slot.sv
module dbm_slot #(
    parameter int AW    = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             clr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             valid_o,
    output logic [AW-1:0]    addr_o,
    output logic [LEN_W-1:0] len_o
);

    logic             valid_q;
    logic [AW-1:0]    addr_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end else if (cap_i && !valid_q) begin
            valid_q <= 1'b1;
            addr_q  <= addr_i;
            len_q   <= len_i;
        end
    end

    assign valid_o = valid_q;
    assign addr_o  = addr_q;
    assign len_o   = len_q;

    // A held request keeps its contents until the controller consumes it.
    assert_slot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !clr_i) |=> (valid_q && $stable(addr_q) && $stable(len_q)));

endmodule

// File: rtl/dbm_gap.sv
module dbm_gap #(
    parameter int DLY_W    = 4,
    parameter int DLY_INIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic late_i,
    input  logic start_i,
    input  logic run_i,
    output logic last_o
);

    localparam logic [DLY_W-1:0] DMAX  = '1;
    localparam logic [DLY_W-1:0] DINIT = DLY_W'(DLY_INIT);
    localparam logic [DLY_W-1:0] DONE  = DLY_W'(1);

    logic [DLY_W-1:0] dly_q;
    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   dbl;
    logic [DLY_W-1:0] half;
    logic [DLY_W-1:0] dly_next;

    assign dbl  = {dly_q, 1'b0};
    assign half = dly_q >> 1;

    always_comb begin
        if (late_i) dly_next = (dbl > {1'b0, DMAX}) ? DMAX : dbl[DLY_W-1:0];
        else        dly_next = (half == '0) ? DONE : half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= DINIT;
            cnt_q <= '0;
        end else begin
            if (grant_i) dly_q <= dly_next;
            if (start_i)                     cnt_q <= dly_q;
            else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - DONE;
        end
    end

    assign last_o = run_i && (cnt_q == DONE);

    assert_delay_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_q != '0));
    assert_gap_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q != '0));

endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
    import dbm_pkg::*;
#(
    parameter int AW       = 16,
    parameter int LEN_W    = 8,
    parameter int DLY_W    = 4,
    parameter int DLY_INIT = 4,
    parameter int LATE_THR = 6,
    parameter int CMD_MIN  = 3,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic             dack_n_i,
    input  logic             chrdy_i,
    output logic             drq_o,
    output logic             master_n_o,
    output logic [AW-1:0]    addr_o,
    output logic             sbhe_n_o,
    output logic             mem_strobe_n_o,
    output logic             done_o
);

    localparam int                CNT_W     = $clog2(CMD_MIN + 1);
    localparam logic [CNT_W-1:0]  CMD_LAST  = CNT_W'(CMD_MIN);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam int                LAT_W     = $clog2(LATE_THR + 2);
    localparam logic [LAT_W-1:0]  LAT_SAT   = LAT_W'(LATE_THR + 1);
    localparam logic [LAT_W-1:0]  LAT_ONE   = LAT_W'(1);
    localparam logic [LAT_W-1:0]  LAT_LIM   = LAT_W'(LATE_THR);
    localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);
    localparam logic [AW-1:0]     ADDR_STEP = AW'(2);

    dbm_state_e state_q, state_d;

    logic             dack_s;
    logic             slot_v;
    logic [AW-1:0]    slot_addr;
    logic [LEN_W-1:0] slot_len;
    logic             gap_last;

    logic             start_burst, from_slot, grant, beat_end;
    logic [AW-1:0]    cur_addr_q;
    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] start_len;
    logic [CNT_W-1:0] cmd_cnt_q;
    logic [LAT_W-1:0] lat_q;
    logic             late;

    // ---------------- sub-blocks ----------------
    dbm_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_dack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dack_n_i),
        .q_o   (dack_s)
    );

    dbm_slot #(.AW(AW), .LEN_W(LEN_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (req_i && (state_q != ST_IDLE)),
        .clr_i   (start_burst && from_slot),
        .addr_i  (req_addr_i),
        .len_i   (req_len_i),
        .valid_o (slot_v),
        .addr_o  (slot_addr),
        .len_o   (slot_len)
    );

    assign late = (lat_q > LAT_LIM);

    dbm_gap #(.DLY_W(DLY_W), .DLY_INIT(DLY_INIT)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_i (grant),
        .late_i  (late),
        .start_i (state_q == ST_DROP),
        .run_i   (state_q == ST_GAP),
        .last_o  (gap_last)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d     = state_q;
        start_burst = 1'b0;
        from_slot   = 1'b0;
        grant       = 1'b0;
        beat_end    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (slot_v) begin
                    state_d     = ST_REQ;
                    start_burst = 1'b1;
                    from_slot   = 1'b1;
                end else if (req_i) begin
                    state_d     = ST_REQ;
                    start_burst = 1'b1;
                end
            end
            ST_REQ: begin
                if (!dack_s) begin
                    state_d = ST_ADDR;
                    grant   = 1'b1;
                end
            end
            ST_ADDR: state_d = ST_CMD;
            ST_CMD: begin
                if (cmd_cnt_q >= CMD_LAST && chrdy_i) begin
                    beat_end = 1'b1;
                    state_d  = (left_q == LEN_ONE) ? ST_DROP : ST_ADDR;
                end
            end
            ST_DROP: state_d = ST_GAP;
            ST_GAP: begin
                if (gap_last) begin
                    if (slot_v) begin
                        state_d     = ST_REQ;
                        start_burst = 1'b1;
                        from_slot   = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- burst datapath ----------------
    assign start_len = from_slot ? slot_len : req_len_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            left_q     <= '0;
            cmd_cnt_q  <= '0;
            lat_q      <= '0;
        end else begin
            if (start_burst) begin
                cur_addr_q <= from_slot ? slot_addr : req_addr_i;
                left_q     <= (start_len == '0) ? LEN_ONE : start_len;
                lat_q      <= LAT_ONE;
            end else if (state_q == ST_REQ && !grant && lat_q != LAT_SAT) begin
                lat_q <= lat_q + LAT_ONE;
            end

            if (state_q == ST_ADDR)
                cmd_cnt_q <= CNT_ONE;
            else if (state_q == ST_CMD && cmd_cnt_q != CMD_LAST)
                cmd_cnt_q <= cmd_cnt_q + CNT_ONE;

            if (beat_end && state_d == ST_ADDR) begin
                cur_addr_q <= cur_addr_q + ADDR_STEP;
                left_q     <= left_q - LEN_ONE;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        drq_o          = 1'b0;
        master_n_o     = 1'b1;
        addr_o         = '0;
        sbhe_n_o       = 1'b1;
        mem_strobe_n_o = 1'b1;
        done_o         = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: ;
            ST_REQ: drq_o = 1'b1;
            ST_ADDR: begin
                drq_o      = 1'b1;
                master_n_o = 1'b0;
                addr_o     = cur_addr_q;
                sbhe_n_o   = 1'b0;
            end
            ST_CMD: begin
                drq_o          = 1'b1;
                master_n_o     = 1'b0;
                addr_o         = cur_addr_q;
                sbhe_n_o       = 1'b0;
                mem_strobe_n_o = 1'b0;
            end
            ST_DROP: begin
                master_n_o = 1'b0;
                done_o     = 1'b1;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  low_run_q <= '0;
        else if (mem_strobe_n_o)     low_run_q <= '0;
        else if (low_run_q != CMD_LAST) low_run_q <= low_run_q + CNT_ONE;
    end

    assert_grant_after_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(master_n_o) |-> $past(drq_o));
    assert_strobe_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_strobe_n_o |-> (!master_n_o && !sbhe_n_o && drq_o));
    assert_min_command_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_strobe_n_o) |-> (low_run_q == CMD_LAST));
    assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_strobe_n_o) |-> $stable(addr_o));
    assert_wait_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && !chrdy_i) |=> (state_q == ST_CMD));
    assert_release_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq_o) |=> $rose(master_n_o));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!drq_o && !master_n_o) ##1 !done_o);

endmodule

// File: tb/sim_dma_bus_master.sv
`timescale 1ns/1ps
module sim_dma_bus_master;

    localparam int AW    = 16;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_i = 1'b0;
    logic [AW-1:0]    req_addr_i = '0;
    logic [LEN_W-1:0] req_len_i = '0;
    logic             dack_n_i = 1'b1;
    logic             chrdy_i = 1'b1;
    logic             drq_o, master_n_o, sbhe_n_o, mem_strobe_n_o, done_o;
    logic [AW-1:0]    addr_o;

    always #10 clk = ~clk;

    dma_bus_master u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
        .req_len_i(req_len_i), .dack_n_i(dack_n_i), .chrdy_i(chrdy_i),
        .drq_o(drq_o), .master_n_o(master_n_o), .addr_o(addr_o),
        .sbhe_n_o(sbhe_n_o), .mem_strobe_n_o(mem_strobe_n_o), .done_o(done_o)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    int  model_d = 4;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        req_i = 1'b0;
    endtask

    function automatic int next_delay(input int d, input int n);
        if (n > 6) return (2 * d > 15) ? 15 : 2 * d;
        return (d / 2 < 1) ? 1 : d / 2;
    endfunction

    // Called at the falling edge where the request line is first seen high.
    task automatic serve(input logic [AW-1:0] a, input int len, input int w, input int pct,
                         input bit q, input logic [AW-1:0] qa, input int qlen);
        int n = 1;
        int words = (len == 0) ? 1 : len;
        int g;
        bit bad;
        for (int k = 0; k < w; k++) begin
            tick();
            n++;
            chk(drq_o && master_n_o, "R3 ownership before acknowledge", master_n_o, 1);
        end
        dack_n_i = 1'b0;
        tick(); n++;
        chk(master_n_o == 1'b1, "R3 sync stage 1", master_n_o, 1);
        tick(); n++;
        chk(master_n_o == 1'b1, "R3 sync stage 2", master_n_o, 1);
        tick();
        chk(master_n_o == 1'b0, "R3 ownership after sync", master_n_o, 0);
        model_d = next_delay(model_d, n);
        for (int i = 0; i < words; i++) begin
            int c = 1;
            logic [AW-1:0] ea = AW'(a + AW'(2 * i));
            chk(addr_o == ea, "R4 address", addr_o, ea);
            chk(mem_strobe_n_o && !sbhe_n_o && drq_o && !master_n_o, "R4 setup clock",
                mem_strobe_n_o, 1);
            if (i == 0 && q) begin
                req_i = 1'b1; req_addr_i = qa; req_len_i = LEN_W'(qlen);
            end
            tick();
            while (1) begin
                bit rdy;
                bit ex;
                chk(!mem_strobe_n_o && addr_o == ea && !sbhe_n_o, "R5 strobe held low",
                    mem_strobe_n_o, 0);
                if (i == 0 && c == 1 && q) begin
                    req_i = 1'b1; req_addr_i = 16'hBEE0; req_len_i = 8'd5;
                end
                if (c < 3) rdy = 1'($urandom_range(0, 1));
                else       rdy = ($urandom_range(0, 99) < pct) || (c > 12);
                chrdy_i = rdy;
                ex = (c >= 3) && rdy;
                tick();
                if (ex) break;
                c++;
            end
        end
        chrdy_i = 1'b1;
        chk(!drq_o && done_o && !master_n_o, "R6 R7 end after last word", done_o, 1);
        dack_n_i = 1'b1;
        if (q) begin
            g = 1;
            tick();
            chk(master_n_o && !done_o, "R7 release one clock later", master_n_o, 1);
            while (!drq_o && g < 40) begin
                g++;
                tick();
            end
            chk(g == model_d + 1, "R8 R9 spacing between bursts", g, model_d + 1);
        end else begin
            tick();
            chk(master_n_o && !done_o, "R7 release one clock later", master_n_o, 1);
            bad = 1'b0;
            repeat (20) begin
                tick();
                if (drq_o) bad = 1'b1;
            end
            chk(!bad, "R10 R2 no further request", bad, 0);
        end
    endtask

    task automatic fresh(input logic [AW-1:0] a, input int len, input int w, input int pct,
                         input bit q, input logic [AW-1:0] qa, input int qlen, input int w2);
        req_addr_i = a; req_len_i = LEN_W'(len); req_i = 1'b1;
        tick();
        chk(drq_o == 1'b1, "R2 request line after pulse", drq_o, 1);
        serve(a, len, w, pct, q, qa, qlen);
        if (q) serve(qa, qlen, w2, pct, 1'b0, '0, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!drq_o && master_n_o && mem_strobe_n_o && sbhe_n_o && !done_o && addr_o == '0,
            "R1 reset outputs", drq_o, 0);
        rst_n = 1'b1;
        tick();
        tick();
        chk(!drq_o, "R2 idle stays quiet", drq_o, 0);

        // Directed: zero length, long wait stretch, saturation up and down.
        fresh(16'h0100, 0, 0, 100, 1'b0, '0, 0, 0);
        fresh(16'hFFFE, 2, 1, 0, 1'b0, '0, 0, 0);
        fresh(16'h2000, 1, 5, 100, 1'b1, 16'h3000, 2, 5);
        fresh(16'h4000, 2, 6, 80, 1'b1, 16'h5000, 1, 0);
        for (int k = 0; k < 4; k++)
            fresh(AW'(16'h6000 + 16'(k * 64)), 1, 0, 100, 1'b1, AW'(16'h7000 + 16'(k * 64)), 1, 0);

        for (int it = 0; it < 25; it++) begin
            fresh(AW'($urandom), $urandom_range(0, 4), $urandom_range(0, 8),
                  $urandom_range(30, 100), 1'($urandom_range(0, 1)), AW'($urandom),
                  $urandom_range(1, 3), $urandom_range(0, 8));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule